// File: doc/BRIEF.md
# Don't-Care Vote Tally Unit

This block picks fill values for the don't-care entries of one k-input look-up table. Its input is the sequence of local input vectors that the table saw during a timed run, one vector per accepted beat and in the order they happened. Alongside the stream it receives the table's truth table and a mask that marks which minterms are don't-cares. A don't-care vector that sits between two care vectors produces a vote, but only when those two neighbouring care vectors give the same output. The vote goes to that shared value. A separate pair of tallies, one toward 0 and one toward 1, is kept for every minterm.

Votes for a run of don't-care vectors depend on the care vector that closes the run. The block therefore holds such occurrences in per-minterm pending counters. When the next care vector arrives, the pending counts are either added to the agreeing tally or discarded. A start pulse clears all tallies and pending state. A finish pulse closes the stream, and the results are latched during the next cycle.

The results are a completed truth table, a flag for every don't-care with no clear winner, and the vote bias of each minterm given as a numerator and denominator pair. A one-cycle done pulse marks when these results are valid. The outputs hold their values until the next finish.

Top module: `dc_vote_tally`

## Requirements
- R1: After reset, and after any start pulse, every tally and every pending count is zero. A finish that follows with no beats in between reports zero votes for every minterm. A start in the same cycle as a finish overrides the finish.
- R2: A vector whose mask bit is 0 is a care vector, and its output is bit `care_tt_i[vec]`. In the completed table, every care minterm keeps its `care_tt_i` bit.
- R3: A don't-care vector (mask bit 1) between two care vectors with the same output adds one vote for that output to its own minterm. Each occurrence counts once.
- R4: When the care vectors on either side of a run of don't-care vectors give different outputs, the whole run is discarded and casts no vote.
- R5: Don't-care vectors that arrive before the first care vector after start, and pending occurrences still open at finish, cast no vote. A finish also forgets the last care output, so voting starts fresh after it.
- R6: Votes are tallied separately for each minterm. A vote for one minterm never changes another minterm's tallies.
- R7: At finish, a don't-care minterm whose 1-tally is larger is filled with 1, and one whose 0-tally is larger is filled with 0. On a tie, including zero votes, it is filled with `default_fill_i` and its `undecided_o` bit is set. The `undecided_o` bit is always 0 for a care minterm.
- R8: For minterm m, lane m of `bias_num_o` holds the larger of the two tallies and lane m of `bias_den_o` holds their sum. Lane m sits at bits [m*TALLY_W +: TALLY_W] and [m*(TALLY_W+1) +: TALLY_W+1].
- R9: Tallies and pending counts saturate at 2^TALLY_W-1 (65535 by default) and never wrap.
- R10: `vec_ready_o` is 1 except in the single cycle after an accepted finish. `done_o` is high for exactly the cycle after that one, and the results are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clear tallies and pending state |
| finish_i | input | 1 | End of stream; latch results next cycle |
| vec_valid_i | input | 1 | Input vector beat valid |
| vec_ready_o | output | 1 | Block can accept a beat |
| vec_i | input | K | Local input vector (minterm index) |
| care_tt_i | input | 2**K | Truth table of the care entries |
| dc_mask_i | input | 2**K | 1 marks a don't-care minterm |
| default_fill_i | input | 1 | Fill value for tied or unvoted don't-cares |
| done_o | output | 1 | One-cycle results-valid pulse |
| filled_tt_o | output | 2**K | Completed truth table |
| undecided_o | output | 2**K | Don't-care filled with the default |
| bias_num_o | output | 2**K*TALLY_W | Per-minterm larger tally |
| bias_den_o | output | 2**K*(TALLY_W+1) | Per-minterm total votes |

## Verification
The hardest situation to reach is tally saturation. It needs more than 65535 don't-care occurrences between agreeing care vectors. The bench streams one long run that saturates the pending counter, then a second short run, so the tally itself must clamp. Disagreeing boundaries, orphan runs before the first care vector or left open at finish, and exact ties are each built from short scripted streams. A pseudo-random stream then exercises many minterms at once against a reference model.

// File: rtl/dvt_pkg.sv
package dvt_pkg;
    typedef enum logic [1:0] {
        BK_IDLE,
        BK_CARE,
        BK_DC_HELD,
        BK_DC_ORPHAN
    } beat_kind_e;
endpackage

// File: rtl/dvt_sat_add.sv
module dvt_sat_add #(
    parameter int AW = 16,
    parameter int IW = 16
) (
    input  logic [AW-1:0] acc_i,
    input  logic [IW-1:0] inc_i,
    output logic [AW-1:0] sum_o
);
    localparam int PADW = AW + 1 - IW;
    logic [AW:0] wide;

    always_comb begin
        wide  = {1'b0, acc_i} + {{PADW{1'b0}}, inc_i};
        sum_o = wide[AW] ? {AW{1'b1}} : wide[AW-1:0];
    end
endmodule

// File: rtl/dvt_resolve.sv
module dvt_resolve #(
    parameter int TW = 16
) (
    input  logic [TW-1:0] votes0_i,
    input  logic [TW-1:0] votes1_i,
    input  logic          is_dc_i,
    input  logic          care_bit_i,
    input  logic          default_fill_i,
    output logic          fill_o,
    output logic          undec_o,
    output logic [TW-1:0] num_o,
    output logic [TW:0]   den_o
);
    logic tie;

    always_comb begin
        tie     = (votes0_i == votes1_i);
        den_o   = {1'b0, votes0_i} + {1'b0, votes1_i};
        num_o   = (votes0_i > votes1_i) ? votes0_i : votes1_i;
        undec_o = is_dc_i & tie;
        if (!is_dc_i) begin
            fill_o = care_bit_i;
        end else if (tie) begin
            fill_o = default_fill_i;
        end else begin
            fill_o = (votes1_i > votes0_i);
        end
    end
endmodule

// File: rtl/dc_vote_tally.sv
module dc_vote_tally
    import dvt_pkg::*;
#(
    parameter int K       = 4,
    parameter int TALLY_W = 16,
    parameter int PEND_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic                           finish_i,
    input  logic                           vec_valid_i,
    output logic                           vec_ready_o,
    input  logic [K-1:0]                   vec_i,
    input  logic [2**K-1:0]                care_tt_i,
    input  logic [2**K-1:0]                dc_mask_i,
    input  logic                           default_fill_i,
    output logic                           done_o,
    output logic [2**K-1:0]                filled_tt_o,
    output logic [2**K-1:0]                undecided_o,
    output logic [2**K*TALLY_W-1:0]        bias_num_o,
    output logic [2**K*(TALLY_W+1)-1:0]    bias_den_o
);
    localparam int NMIN = 2 ** K;

    typedef struct packed {
        logic [NMIN-1:0][PEND_W-1:0]  pend;
        logic [NMIN-1:0][TALLY_W-1:0] tally0;
        logic [NMIN-1:0][TALLY_W-1:0] tally1;
        logic                         seen_care;
        logic                         prev_val;
        logic                         latch;
        logic                         done;
        logic [NMIN-1:0]              fill;
        logic [NMIN-1:0]              undec;
        logic [NMIN-1:0][TALLY_W-1:0] num;
        logic [NMIN-1:0][TALLY_W:0]   den;
    } state_t;

    state_t st_d, st_q;

    logic                         accept;
    logic                         care_val;
    logic                         agree;
    beat_kind_e                   kind;
    logic [NMIN-1:0][TALLY_W-1:0] sum0, sum1, rnum;
    logic [NMIN-1:0][PEND_W-1:0]  pend_inc;
    logic [NMIN-1:0][TALLY_W:0]   rden;
    logic [NMIN-1:0]              rfill, rundec;

    // Per-minterm saturating adders and result resolution
    for (genvar m = 0; m < NMIN; m++) begin : g_min
        dvt_sat_add #(.AW(TALLY_W), .IW(PEND_W)) u_add0 (
            .acc_i(st_q.tally0[m]), .inc_i(st_q.pend[m]), .sum_o(sum0[m]));
        dvt_sat_add #(.AW(TALLY_W), .IW(PEND_W)) u_add1 (
            .acc_i(st_q.tally1[m]), .inc_i(st_q.pend[m]), .sum_o(sum1[m]));
        dvt_sat_add #(.AW(PEND_W), .IW(1)) u_pinc (
            .acc_i(st_q.pend[m]), .inc_i(1'b1), .sum_o(pend_inc[m]));
        dvt_resolve #(.TW(TALLY_W)) u_res (
            .votes0_i      (st_q.tally0[m]),
            .votes1_i      (st_q.tally1[m]),
            .is_dc_i       (dc_mask_i[m]),
            .care_bit_i    (care_tt_i[m]),
            .default_fill_i(default_fill_i),
            .fill_o        (rfill[m]),
            .undec_o       (rundec[m]),
            .num_o         (rnum[m]),
            .den_o         (rden[m])
        );
        assign bias_num_o[m*TALLY_W +: TALLY_W]         = st_q.num[m];
        assign bias_den_o[m*(TALLY_W+1) +: TALLY_W+1]   = st_q.den[m];
    end

    assign vec_ready_o = !st_q.latch;
    assign done_o      = st_q.done;
    assign filled_tt_o = st_q.fill;
    assign undecided_o = st_q.undec;

    always_comb begin
        accept   = vec_valid_i && vec_ready_o;
        care_val = care_tt_i[vec_i];
        agree    = st_q.seen_care && (st_q.prev_val == care_val);
        if (!accept) begin
            kind = BK_IDLE;
        end else if (!dc_mask_i[vec_i]) begin
            kind = BK_CARE;
        end else if (st_q.seen_care) begin
            kind = BK_DC_HELD;
        end else begin
            kind = BK_DC_ORPHAN;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.latch = 1'b0;
        if (start_i) begin
            st_d.pend      = '0;
            st_d.tally0    = '0;
            st_d.tally1    = '0;
            st_d.seen_care = 1'b0;
            st_d.prev_val  = 1'b0;
        end else begin
            if (st_q.latch) begin
                st_d.fill      = rfill;
                st_d.undec     = rundec;
                st_d.num       = rnum;
                st_d.den       = rden;
                st_d.done      = 1'b1;
                st_d.pend      = '0;
                st_d.seen_care = 1'b0;
            end
            case (kind)
                BK_CARE: begin
                    if (agree) begin
                        for (int m = 0; m < NMIN; m++) begin
                            if (care_val) begin
                                st_d.tally1[m] = sum1[m];
                            end else begin
                                st_d.tally0[m] = sum0[m];
                            end
                        end
                    end
                    st_d.pend      = '0;
                    st_d.seen_care = 1'b1;
                    st_d.prev_val  = care_val;
                end
                BK_DC_HELD: st_d.pend[vec_i] = pend_inc[vec_i];
                default: ;
            endcase
            if (finish_i) begin
                st_d.latch = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dvt_checker.sv
module dvt_checker #(
    parameter int K       = 4,
    parameter int TALLY_W = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start_i,
    input logic                        finish_i,
    input logic                        vec_ready_o,
    input logic                        done_o,
    input logic [2**K-1:0]             care_tt_i,
    input logic [2**K-1:0]             dc_mask_i,
    input logic                        default_fill_i,
    input logic [2**K-1:0]             filled_tt_o,
    input logic [2**K-1:0]             undecided_o,
    input logic [2**K*TALLY_W-1:0]     bias_num_o,
    input logic [2**K*(TALLY_W+1)-1:0] bias_den_o
);
    localparam int NMIN = 2 ** K;

    p_finish_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_i && !start_i) |=> !vec_ready_o);

    p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_ready_o && !start_i) |=> done_o);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && vec_ready_o) |=> !done_o);

    p_care_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (((filled_tt_o ^ $past(care_tt_i)) & ~$past(dc_mask_i)) == '0));

    p_undec_dc_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((undecided_o & ~$past(dc_mask_i)) == '0));

    for (genvar m = 0; m < NMIN; m++) begin : g_chk
        p_bias_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> ({1'b0, bias_num_o[m*TALLY_W +: TALLY_W]} <= bias_den_o[m*(TALLY_W+1) +: TALLY_W+1])
                    && ({bias_num_o[m*TALLY_W +: TALLY_W], 1'b0} >= bias_den_o[m*(TALLY_W+1) +: TALLY_W+1]));

        p_default_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && undecided_o[m]) |-> (filled_tt_o[m] == $past(default_fill_i)));
    end
endmodule

bind dc_vote_tally dvt_checker #(.K(K), .TALLY_W(TALLY_W)) u_dvt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .finish_i      (finish_i),
    .vec_ready_o   (vec_ready_o),
    .done_o        (done_o),
    .care_tt_i     (care_tt_i),
    .dc_mask_i     (dc_mask_i),
    .default_fill_i(default_fill_i),
    .filled_tt_o   (filled_tt_o),
    .undecided_o   (undecided_o),
    .bias_num_o    (bias_num_o),
    .bias_den_o    (bias_den_o)
);

// File: tb/tb_dc_vote_tally.sv
module tb_dc_vote_tally;
    localparam int K    = 4;
    localparam int TW   = 16;
    localparam int NM   = 16;
    localparam int MAXV = 65535;
    localparam logic [15:0] CARE = 16'h4A51; // minterm0 -> 1, minterm1 -> 0
    localparam logic [15:0] MASK = 16'h9228; // don't-cares: 3,5,9,12,15

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, finish_i = 1'b0, vec_valid_i = 1'b0, default_fill_i = 1'b0;
    logic [K-1:0] vec_i = '0;
    logic vec_ready_o, done_o;
    logic [NM-1:0] filled_tt_o, undecided_o;
    logic [NM*TW-1:0] bias_num_o;
    logic [NM*(TW+1)-1:0] bias_den_o;

    always #2.5 clk = ~clk;

    dc_vote_tally #(.K(K), .TALLY_W(TW), .PEND_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .finish_i(finish_i),
        .vec_valid_i(vec_valid_i), .vec_ready_o(vec_ready_o), .vec_i(vec_i),
        .care_tt_i(CARE), .dc_mask_i(MASK), .default_fill_i(default_fill_i),
        .done_o(done_o), .filled_tt_o(filled_tt_o), .undecided_o(undecided_o),
        .bias_num_o(bias_num_o), .bias_den_o(bias_den_o));

    int compared = 0;
    int mismatched = 0;
    bit ended = 1'b0;

    // reference model state
    int m_t0[NM], m_t1[NM], m_pend[NM];
    bit m_seen, m_prev;

    typedef struct packed {
        logic [NM-1:0]        fill;
        logic [NM-1:0]        undec;
        logic [NM-1:0][15:0]  num;
        logic [NM-1:0][16:0]  den;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int sat(input int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    task automatic drive(input bit st, input bit fin, input bit val, input int v);
        start_i = st; finish_i = fin; vec_valid_i = val; vec_i = K'(v);
    endtask

    task automatic model_clear();
        for (int m = 0; m < NM; m++) begin m_t0[m] = 0; m_t1[m] = 0; m_pend[m] = 0; end
        m_seen = 1'b0; m_prev = 1'b0;
    endtask

    task automatic send(input int v);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, v);
        if (!MASK[v]) begin
            if (m_seen && (m_prev == CARE[v])) begin
                for (int m = 0; m < NM; m++) begin
                    if (CARE[v]) m_t1[m] = sat(m_t1[m] + m_pend[m]);
                    else         m_t0[m] = sat(m_t0[m] + m_pend[m]);
                end
            end
            for (int m = 0; m < NM; m++) m_pend[m] = 0;
            m_seen = 1'b1; m_prev = CARE[v];
        end else if (m_seen) begin
            m_pend[v] = sat(m_pend[v] + 1);
        end
    endtask

    task automatic send_n(input int v, input int n);
        for (int i = 0; i < n; i++) send(v);
    endtask

    task automatic do_start();
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 0);
        model_clear();
    endtask

    // driver: pushes the expected result of this finish into the scoreboard
    task automatic do_finish(input string tag, input bit dflt);
        exp_t e;
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 0);
        default_fill_i = dflt;
        for (int m = 0; m < NM; m++) begin
            if (!MASK[m]) begin
                e.fill[m] = CARE[m]; e.undec[m] = 1'b0;
            end else begin
                e.undec[m] = (m_t0[m] == m_t1[m]);
                e.fill[m]  = e.undec[m] ? dflt : (m_t1[m] > m_t0[m]);
            end
            e.num[m] = 16'((m_t0[m] > m_t1[m]) ? m_t0[m] : m_t1[m]);
            e.den[m] = 17'(m_t0[m] + m_t1[m]);
            m_pend[m] = 0;
        end
        m_seen = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 0);
        check(vec_ready_o == 1'b0, "R10", "ready low in latch cycle", vec_ready_o, 0);
        @(negedge clk); // monitor compares here
        @(negedge clk);
        check(done_o == 1'b0, "R10", "done single pulse", done_o, 0);
        check(vec_ready_o == 1'b1, "R10", "ready back after latch", vec_ready_o, 1);
    endtask

    // monitor: pops and compares when results appear
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                for (int m = 0; m < NM; m++) begin
                    check(filled_tt_o[m] == e.fill[m], MASK[m] ? {t, "/R7"} : {t, "/R2"},
                          $sformatf("fill[%0d]", m), filled_tt_o[m], e.fill[m]);
                    check(undecided_o[m] == e.undec[m], {t, "/R7"},
                          $sformatf("undecided[%0d]", m), undecided_o[m], e.undec[m]);
                    check(bias_num_o[m*TW +: TW] == e.num[m], {t, "/R8"},
                          $sformatf("bias_num[%0d]", m), bias_num_o[m*TW +: TW], e.num[m]);
                    check(bias_den_o[m*(TW+1) +: TW+1] == e.den[m], {t, "/R8"},
                          $sformatf("bias_den[%0d]", m), bias_den_o[m*(TW+1) +: TW+1], e.den[m]);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            mismatched++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R10: reset state
        check(vec_ready_o == 1'b1, "R10", "ready after reset", vec_ready_o, 1);
        check(done_o == 1'b0, "R1", "done after reset", done_o, 0);

        // R1 + R7: no beats, all don't-cares tie at zero -> default 1
        do_start();
        do_finish("R1", 1'b1);

        // R3 + R6: agreeing sides, separate minterms
        do_start();
        send(0); send_n(3, 2); send(5); send(0);   // m3 +2 ones, m5 +1 one
        send(1); send(9); send(3); send(1);        // m9 +1 zero, m3 +1 zero
        do_finish("R3", 1'b0);

        // R1: start clears the tallies built above
        do_start();
        do_finish("R1", 1'b0);

        // R4: disagreeing run discarded, later agreeing run counts
        do_start();
        send(0); send_n(12, 3); send(1);
        send(12); send(1);
        do_finish("R4", 1'b1);

        // R5: orphans before first care, open run at finish, start mid-run
        do_start();
        send_n(15, 4); send(0); send_n(15, 2);
        do_finish("R5", 1'b0);
        send(0); send(3);
        do_start();
        send(0);                                   // prior care forgotten: no vote for m3
        send(3); send(1);                          // sides 1 vs 0: discarded
        do_finish("R5", 1'b0);

        // R7: exact tie
        do_start();
        send(0); send(5); send(0);
        send(1); send(5); send(1);
        do_finish("R7", 1'b1);

        // R6/R8: pseudo-random stream
        do_start();
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            send(int'(lf[3:0]));
        end
        do_finish("R6", 1'b0);

        // R9: saturation of pending and tally
        do_start();
        send(0); send_n(3, MAXV + 5); send(0);
        send_n(3, 10); send(0);
        send(1); send_n(3, 3); send(1);
        do_finish("R9", 1'b0);

        ended = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule